// File: doc/BRIEF.md
# Speculative Row Activation Gate

This block sits beside a DRAM command scheduler and decides, once per cycle, whether a speculative row activation is worth issuing and on behalf of which thread. Each thread offers a predicted target (channel, rank, bank, row), together with its traffic light, its count of outstanding reads and the value of its oldest pending request. A thread qualifies only when it is ready to make use of an early-opened row. Its target rank must also be idle, the target bank must not be opened already, and the rank must still have room in its four-activate window.

Among the qualifying threads the gate picks the one with the smallest score. It issues the activation only while a global confidence counter says that recent speculative openings have paid off. The scheduler later reports whether each speculatively opened row was used, and the counter moves by +1 or -3 to match. The gate keeps a short history of activation times for every rank. Both its own activations and activations reported by the scheduler are recorded there, so that speculation never pushes a rank into the activate-window limit. Speculation has the lowest priority: it gives way whenever the scheduler activates in the same cycle.

Top module: `spec_act_gate`

## Requirements
- R1: After reset `spec_valid` is 0 and the confidence counter holds its maximum, 31. The first qualifying cycle after reset therefore issues.
- R2: A thread qualifies only if its light is green (`thr_green` = 1) and `thr_reads` is at most 2.
- R3: A thread qualifies only if `rank_reads` of its target rank is 0 and `bank_primed` of its target bank is 0. The rank index is chan*RANKS+rank and the bank index is rankindex*BANKS+bank.
- R4: Each rank records its last four activations, replacing the oldest record when a new one arrives. An activation made in cycle c is counted in cycles c+1 through c+TFAW-1. A thread qualifies only while fewer than 3 activations are counted on its target rank.
- R5: Each qualifying thread is scored as `thr_oldest` + 100*`thr_reads`. The lowest score wins, and on a tie the lowest thread index wins.
- R6: The confidence counter is a signed 6-bit value. An activation is issued only while the counter is at least 28.
- R7: A feedback pulse with `fb_used`=1 adds 1 to the counter, saturating at 31. A feedback pulse with `fb_used`=0 subtracts 3, saturating at -32. The new value takes effect from the next cycle.
- R8: A decision taken in cycle c appears in cycle c+1 as a one-cycle `spec_valid` pulse carrying the winner's thread index and address. When no thread qualifies, nothing is issued.
- R9: An external activation (`ext_act_valid`) suppresses any speculative issue in the same cycle and is recorded in the history of its own rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_chan | input | THREADS x CH_W | Predicted channel per thread |
| pred_rank | input | THREADS x RK_W | Predicted rank per thread |
| pred_bank | input | THREADS x BK_W | Predicted bank per thread |
| pred_row | input | THREADS x ROW_W | Predicted row per thread |
| thr_green | input | THREADS | Traffic light per thread, 1 = green |
| thr_reads | input | THREADS x CNT_W | Outstanding reads per thread |
| thr_oldest | input | THREADS x VAL_W | Value of the thread's oldest request |
| rank_reads | input | RANKS_ALL x CNT_W | Pending reads per rank |
| bank_primed | input | BANKS_ALL | Bank already preactivated |
| ext_act_valid | input | 1 | Scheduler issues an activation this cycle |
| ext_act_chan | input | CH_W | Channel of that activation |
| ext_act_rank | input | RK_W | Rank of that activation |
| fb_valid | input | 1 | Feedback on a speculative row |
| fb_used | input | 1 | 1 = the row was used, 0 = wasted |
| spec_valid | output | 1 | Speculative activation request |
| spec_thread | output | TH_W | Winning thread |
| spec_chan | output | CH_W | Channel to activate |
| spec_rank | output | RK_W | Rank to activate |
| spec_bank | output | BK_W | Bank to activate |
| spec_row | output | ROW_W | Row to activate |

## Verification
A corrupted activation record shows up as a wrong `spec_valid` within one cycle. An extra record blocks a rank up to TFAW-1 cycles too long, and a missing record lets a fourth activation through. A confidence counter that wraps instead of saturating is exposed within one decision after the last feedback pulse, by an issue that should have been held back or a hold that should have issued. Selection errors appear at the winner's thread index and address in the very next cycle. The bench therefore drives feedback past both saturation limits and lets activations age across the window edge.

// File: rtl/sag_pkg.sv
package sag_pkg;

    // Records kept per rank and the count that closes the window for speculation.
    localparam int SLOTS      = 4;
    localparam int SLOT_W     = 2;
    localparam int BUSY_LIMIT = 3;
    localparam int READ_SLOPE = 100;
    localparam int READ_CAP   = 2;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int clip(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/sag_window.sv
module sag_window
    import sag_pkg::*;
#(
    parameter int STAMP_W = 8,
    parameter int TFAW    = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STAMP_W-1:0] now,
    input  logic               rec,
    output logic [2:0]         live_cnt
);

    logic [SLOTS-1:0]              vld;
    logic [SLOTS-1:0][STAMP_W-1:0] stamp;
    logic [SLOTS-1:0][STAMP_W-1:0] age;
    logic [SLOTS-1:0]              inwin;
    logic [SLOT_W-1:0]             victim;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            age[i]   = now - stamp[i];
            inwin[i] = vld[i] && (age[i] < STAMP_W'(TFAW));
        end
        live_cnt = 3'($countones(inwin));
    end

    // Free slot first; otherwise the record with the largest age.
    always_comb begin
        logic found;
        logic [STAMP_W-1:0] oldest;
        found  = 1'b0;
        victim = '0;
        oldest = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!found && !inwin[i]) begin
                found  = 1'b1;
                victim = SLOT_W'(i);
            end
        end
        if (!found) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (age[i] > oldest) begin
                    oldest = age[i];
                    victim = SLOT_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld   <= '0;
            stamp <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (rec && victim == SLOT_W'(i)) begin
                    vld[i]   <= 1'b1;
                    stamp[i] <= now;
                end else begin
                    vld[i]   <= inwin[i];
                end
            end
        end
    end

    // R4: a fresh activation is counted in the following cycle
    a_r4_record_counts: assert property (@(posedge clk) disable iff (rst)
        rec |=> live_cnt != 3'd0);

    // R4: without a new record the count can never grow
    a_r4_no_growth: assert property (@(posedge clk) disable iff (rst)
        !rec |=> live_cnt <= $past(live_cnt));

endmodule

// File: rtl/sag_conf.sv
module sag_conf
    import sag_pkg::*;
#(
    parameter int CONF_W = 6,
    parameter int THRESH = 28
) (
    input  logic clk,
    input  logic rst,
    input  logic fb_valid,
    input  logic fb_used,
    output logic conf_ok
);

    localparam int MAXV = 2 ** (CONF_W - 1) - 1;
    localparam int MINV = -(2 ** (CONF_W - 1));

    logic signed [CONF_W-1:0] conf;
    int cv;
    int nv;

    always_comb begin
        cv      = int'(conf);
        nv      = clip(fb_used ? cv + 1 : cv - 3, MINV, MAXV);
        conf_ok = (cv >= THRESH);
    end

    always_ff @(posedge clk) begin
        if (rst)           conf <= CONF_W'(MAXV);
        else if (fb_valid) conf <= CONF_W'(nv);
    end

    // R7: ceiling holds
    a_r7_ceiling: assert property (@(posedge clk) disable iff (rst)
        fb_valid && fb_used && cv == MAXV |=> cv == MAXV);
    // R7: floor holds
    a_r7_floor: assert property (@(posedge clk) disable iff (rst)
        fb_valid && !fb_used && cv < MINV + 3 |=> cv == MINV);
    // R7: unsaturated steps
    a_r7_step_up: assert property (@(posedge clk) disable iff (rst)
        fb_valid && fb_used && cv < MAXV |=> cv == $past(cv) + 1);
    a_r7_step_down: assert property (@(posedge clk) disable iff (rst)
        fb_valid && !fb_used && cv >= MINV + 3 |=> cv == $past(cv) - 3);
    // R7: no feedback, no change
    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        !fb_valid |=> $stable(conf));

endmodule

// File: rtl/sag_pick.sv
module sag_pick
    import sag_pkg::*;
#(
    parameter int NT   = 4,
    parameter int SC_W = 27,
    parameter int TH_W = 2
) (
    input  logic [NT-1:0]           elig,
    input  logic [NT-1:0][SC_W-1:0] score,
    output logic                    any,
    output logic [TH_W-1:0]         sel
);

    always_comb begin
        logic [SC_W-1:0] best;
        any  = 1'b0;
        sel  = '0;
        best = '0;
        for (int t = 0; t < NT; t++) begin
            if (elig[t] && (!any || score[t] < best)) begin
                any  = 1'b1;
                sel  = TH_W'(t);
                best = score[t];
            end
        end
    end

    always_comb begin
        if (any && !$isunknown(sel) && !$isunknown(elig) && !$isunknown(score)) begin
            a_r5_pick_eligible: assert (elig[sel]);
            for (int t = 0; t < NT; t++) begin
                // R5: no eligible thread beats the winner, ties go low
                a_r5_pick_min: assert (!(elig[t] && score[t] < score[sel]));
                a_r5_pick_tie: assert (!(elig[t] && t < int'(sel) && score[t] == score[sel]));
            end
        end
    end

endmodule

// File: rtl/spec_act_gate.sv
module spec_act_gate
    import sag_pkg::*;
#(
    parameter int THREADS = 4,
    parameter int CHANS   = 2,
    parameter int RANKS   = 2,
    parameter int BANKS   = 8,
    parameter int ROW_W   = 14,
    parameter int VAL_W   = 12,
    parameter int CNT_W   = 8,
    parameter int TFAW    = 24,
    parameter int STAMP_W = 8,
    parameter int CONF_W  = 6,
    parameter int THRESH  = 28,
    localparam int CH_W      = idx_w(CHANS),
    localparam int RK_W      = idx_w(RANKS),
    localparam int BK_W      = idx_w(BANKS),
    localparam int TH_W      = idx_w(THREADS),
    localparam int RANKS_ALL = CHANS * RANKS,
    localparam int BANKS_ALL = RANKS_ALL * BANKS
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [THREADS-1:0][CH_W-1:0]     pred_chan,
    input  logic [THREADS-1:0][RK_W-1:0]     pred_rank,
    input  logic [THREADS-1:0][BK_W-1:0]     pred_bank,
    input  logic [THREADS-1:0][ROW_W-1:0]    pred_row,
    input  logic [THREADS-1:0]               thr_green,
    input  logic [THREADS-1:0][CNT_W-1:0]    thr_reads,
    input  logic [THREADS-1:0][VAL_W-1:0]    thr_oldest,
    input  logic [RANKS_ALL-1:0][CNT_W-1:0]  rank_reads,
    input  logic [BANKS_ALL-1:0]             bank_primed,
    input  logic                             ext_act_valid,
    input  logic [CH_W-1:0]                  ext_act_chan,
    input  logic [RK_W-1:0]                  ext_act_rank,
    input  logic                             fb_valid,
    input  logic                             fb_used,
    output logic                             spec_valid,
    output logic [TH_W-1:0]                  spec_thread,
    output logic [CH_W-1:0]                  spec_chan,
    output logic [RK_W-1:0]                  spec_rank,
    output logic [BK_W-1:0]                  spec_bank,
    output logic [ROW_W-1:0]                 spec_row
);

    localparam int RG_W = idx_w(RANKS_ALL);
    localparam int BG_W = idx_w(BANKS_ALL);
    localparam int SC_W = VAL_W + CNT_W + 7;

    logic [STAMP_W-1:0]                now;
    logic [THREADS-1:0][RG_W-1:0]      rg;
    logic [THREADS-1:0][BG_W-1:0]      bg;
    logic [THREADS-1:0]                elig;
    logic [THREADS-1:0][SC_W-1:0]      score;
    logic [RANKS_ALL-1:0][2:0]         live;
    logic [RANKS_ALL-1:0]              rec;
    logic [RG_W-1:0]                   ext_rg;
    logic                              any;
    logic [TH_W-1:0]                   sel;
    logic                              conf_ok;
    logic                              issue;

    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            rg[t]    = RG_W'(int'(pred_chan[t]) * RANKS + int'(pred_rank[t]));
            bg[t]    = BG_W'(int'(rg[t]) * BANKS + int'(pred_bank[t]));
            elig[t]  = thr_green[t]
                    && (thr_reads[t] <= CNT_W'(READ_CAP))
                    && (rank_reads[rg[t]] == '0)
                    && !bank_primed[bg[t]]
                    && (live[rg[t]] < 3'(BUSY_LIMIT));
            score[t] = SC_W'(thr_oldest[t]) + SC_W'(thr_reads[t]) * SC_W'(READ_SLOPE);
        end
        ext_rg = RG_W'(int'(ext_act_chan) * RANKS + int'(ext_act_rank));
        issue  = any && conf_ok && !ext_act_valid;
        for (int r = 0; r < RANKS_ALL; r++) begin
            rec[r] = (ext_act_valid && ext_rg == RG_W'(r))
                  || (issue && rg[sel] == RG_W'(r));
        end
    end

    sag_pick #(.NT(THREADS), .SC_W(SC_W), .TH_W(TH_W)) u_pick (
        .elig (elig),
        .score(score),
        .any  (any),
        .sel  (sel)
    );

    sag_conf #(.CONF_W(CONF_W), .THRESH(THRESH)) u_conf (
        .clk     (clk),
        .rst     (rst),
        .fb_valid(fb_valid),
        .fb_used (fb_used),
        .conf_ok (conf_ok)
    );

    for (genvar r = 0; r < RANKS_ALL; r++) begin : g_rank
        sag_window #(.STAMP_W(STAMP_W), .TFAW(TFAW)) u_win (
            .clk     (clk),
            .rst     (rst),
            .now     (now),
            .rec     (rec[r]),
            .live_cnt(live[r])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now         <= '0;
            spec_valid  <= 1'b0;
            spec_thread <= '0;
            spec_chan   <= '0;
            spec_rank   <= '0;
            spec_bank   <= '0;
            spec_row    <= '0;
        end else begin
            now        <= now + 1'b1;
            spec_valid <= issue;
            if (issue) begin
                spec_thread <= sel;
                spec_chan   <= pred_chan[sel];
                spec_rank   <= pred_rank[sel];
                spec_bank   <= pred_bank[sel];
                spec_row    <= pred_row[sel];
            end
        end
    end

    // R9: speculation yields to a scheduler activation
    a_r9_ext_yield: assert property (@(posedge clk) disable iff (rst)
        spec_valid |-> !$past(ext_act_valid));
    // R6: issue only with enough confidence
    a_r6_conf_gate: assert property (@(posedge clk) disable iff (rst)
        spec_valid |-> $past(conf_ok));
    // R4: the winner's rank had room in its window
    a_r4_window_gate: assert property (@(posedge clk) disable iff (rst)
        spec_valid |-> $past(live[rg[sel]]) < 3'(BUSY_LIMIT));
    // R2: the winner was green with few reads
    a_r2_thread_gate: assert property (@(posedge clk) disable iff (rst)
        spec_valid |-> $past(thr_green[sel] && thr_reads[sel] <= CNT_W'(READ_CAP)));

endmodule

// File: tb/sim_spec_act_gate.sv
module sim_spec_act_gate;

    localparam int NT     = 4;
    localparam int NCH    = 2;
    localparam int NRK    = 2;
    localparam int NBK    = 4;
    localparam int ROW_W  = 8;
    localparam int VAL_W  = 10;
    localparam int CNT_W  = 4;
    localparam int TFAW   = 12;
    localparam int CH_W   = 1;
    localparam int RK_W   = 1;
    localparam int BK_W   = 2;
    localparam int TH_W   = 2;
    localparam int NRG    = NCH * NRK;
    localparam int NBG    = NRG * NBK;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NT-1:0][CH_W-1:0]   pred_chan;
    logic [NT-1:0][RK_W-1:0]   pred_rank;
    logic [NT-1:0][BK_W-1:0]   pred_bank;
    logic [NT-1:0][ROW_W-1:0]  pred_row;
    logic [NT-1:0]             thr_green;
    logic [NT-1:0][CNT_W-1:0]  thr_reads;
    logic [NT-1:0][VAL_W-1:0]  thr_oldest;
    logic [NRG-1:0][CNT_W-1:0] rank_reads;
    logic [NBG-1:0]            bank_primed;
    logic                      ext_act_valid;
    logic [CH_W-1:0]           ext_act_chan;
    logic [RK_W-1:0]           ext_act_rank;
    logic                      fb_valid;
    logic                      fb_used;
    logic                      spec_valid;
    logic [TH_W-1:0]           spec_thread;
    logic [CH_W-1:0]           spec_chan;
    logic [RK_W-1:0]           spec_rank;
    logic [BK_W-1:0]           spec_bank;
    logic [ROW_W-1:0]          spec_row;

    spec_act_gate #(.THREADS(NT), .CHANS(NCH), .RANKS(NRK), .BANKS(NBK), .ROW_W(ROW_W),
                    .VAL_W(VAL_W), .CNT_W(CNT_W), .TFAW(TFAW), .STAMP_W(8),
                    .CONF_W(6), .THRESH(28)) u0 (.*);

    // Driven values
    int d_ch[NT], d_rk[NT], d_bk[NT], d_row[NT], d_green[NT], d_reads[NT], d_old[NT];
    int d_rr[NRG];
    int d_bp[NBG];
    int e_v, e_ch, e_rk, f_v, f_u;

    // Reference model state
    int mconf;
    int bc;
    int hist[NRG][512];
    int hn[NRG];

    // Scoreboard
    int q_v[$], q_t[$], q_ch[$], q_rk[$], q_bk[$], q_row[$];
    string q_tag[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    function automatic int live_of(int r, int n);
        int c = 0;
        for (int i = 0; i < hn[r]; i++)
            if (n - hist[r][i] > 0 && n - hist[r][i] < TFAW) c++;
        return c;
    endfunction

    task automatic apply();
        for (int t = 0; t < NT; t++) begin
            pred_chan[t]  = CH_W'(d_ch[t]);
            pred_rank[t]  = RK_W'(d_rk[t]);
            pred_bank[t]  = BK_W'(d_bk[t]);
            pred_row[t]   = ROW_W'(d_row[t]);
            thr_green[t]  = (d_green[t] != 0);
            thr_reads[t]  = CNT_W'(d_reads[t]);
            thr_oldest[t] = VAL_W'(d_old[t]);
        end
        for (int r = 0; r < NRG; r++) rank_reads[r] = CNT_W'(d_rr[r]);
        for (int b = 0; b < NBG; b++) bank_primed[b] = (d_bp[b] != 0);
        ext_act_valid = (e_v != 0);
        ext_act_chan  = CH_W'(e_ch);
        ext_act_rank  = RK_W'(e_rk);
        fb_valid      = (f_v != 0);
        fb_used       = (f_u != 0);
    endtask

    task automatic all_red();
        for (int t = 0; t < NT; t++) begin
            d_ch[t] = t / NRK; d_rk[t] = t % NRK; d_bk[t] = t; d_row[t] = 20 + t;
            d_green[t] = 0; d_reads[t] = 0; d_old[t] = 0;
        end
        for (int r = 0; r < NRG; r++) d_rr[r] = 0;
        for (int b = 0; b < NBG; b++) d_bp[b] = 0;
    endtask

    // Driver: one cycle of stimulus plus its predicted result
    task automatic step(string tag);
        int best, bs, iss;
        apply();
        best = -1; bs = 0;
        for (int t = 0; t < NT; t++) begin
            int rg, bg, sc;
            rg = d_ch[t] * NRK + d_rk[t];
            bg = rg * NBK + d_bk[t];
            if (d_green[t] != 0 && d_reads[t] <= 2 && d_rr[rg] == 0 && d_bp[bg] == 0
                && live_of(rg, bc) < 3) begin
                sc = d_old[t] + 100 * d_reads[t];
                if (best < 0 || sc < bs) begin best = t; bs = sc; end
            end
        end
        iss = (best >= 0 && mconf >= 28 && e_v == 0) ? 1 : 0;
        if (e_v != 0) begin
            int r = e_ch * NRK + e_rk;
            hist[r][hn[r]] = bc; hn[r]++;
        end
        if (iss != 0) begin
            int r = d_ch[best] * NRK + d_rk[best];
            hist[r][hn[r]] = bc; hn[r]++;
        end
        q_v.push_back(iss);
        q_t.push_back(best < 0 ? 0 : best);
        q_ch.push_back(best < 0 ? 0 : d_ch[best]);
        q_rk.push_back(best < 0 ? 0 : d_rk[best]);
        q_bk.push_back(best < 0 ? 0 : d_bk[best]);
        q_row.push_back(best < 0 ? 0 : d_row[best]);
        q_tag.push_back(tag);
        if (f_v != 0) mconf = (f_u != 0) ? ((mconf + 1 > 31) ? 31 : mconf + 1)
                                         : ((mconf - 3 < -32) ? -32 : mconf - 3);
        bc++;
        @(negedge clk);
        e_v = 0; f_v = 0;
    endtask

    task automatic idle(int n);
        all_red();
        for (int i = 0; i < n; i++) step("R8 idle");
    endtask

    task automatic fb_step(int used, string tag);
        all_red();
        f_v = 1; f_u = used;
        step(tag);
    endtask

    // Monitor
    always @(posedge clk) begin
        #1;
        if (q_v.size() > 0) begin
            int ev, et, ec, er, eb, ew;
            string tg;
            ev = q_v.pop_front(); et = q_t.pop_front(); ec = q_ch.pop_front();
            er = q_rk.pop_front(); eb = q_bk.pop_front(); ew = q_row.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if (int'(spec_valid) != ev ||
                (ev != 0 && (int'(spec_thread) != et || int'(spec_chan) != ec ||
                             int'(spec_rank) != er || int'(spec_bank) != eb ||
                             int'(spec_row) != ew))) begin
                fails++;
                $display("FAIL %s: got v=%0d t=%0d ch=%0d rk=%0d bk=%0d row=%0d, expected v=%0d t=%0d ch=%0d rk=%0d bk=%0d row=%0d",
                         tg, spec_valid, spec_thread, spec_chan, spec_rank, spec_bank, spec_row,
                         ev, et, ec, er, eb, ew);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got running, expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        mconf = 31; bc = 0;
        for (int r = 0; r < NRG; r++) hn[r] = 0;
        e_v = 0; e_ch = 0; e_rk = 0; f_v = 0; f_u = 0;
        all_red();
        apply();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checks++;
        if (spec_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: got spec_valid=%0d, expected 0", spec_valid);
        end

        // R1: quiet after reset, then the first qualifying cycle issues
        step("R1 quiet");
        d_green[0] = 1; step("R1 first issue");
        all_red(); step("R8 single pulse");
        idle(TFAW);

        // R5: lowest score, tie to lowest index
        d_green[0] = 1; d_old[0] = 50;
        d_green[1] = 1; d_old[1] = 30;
        d_green[2] = 1; d_old[2] = 30;
        step("R5 tie lowest index");
        idle(TFAW);
        d_green[0] = 1; d_reads[0] = 1; d_old[0] = 0;
        d_green[1] = 1; d_reads[1] = 0; d_old[1] = 99;
        step("R5 read weight");
        d_old[1] = 100; step("R5 weighted tie");
        idle(TFAW);

        // R2: light and read count
        d_green[0] = 1; d_reads[0] = 3; step("R2 too many reads");
        d_green[0] = 0; d_reads[0] = 0; step("R2 red light");
        d_green[0] = 1; d_reads[0] = 2; step("R2 two reads ok");
        idle(TFAW);

        // R3: rank and bank idleness
        d_green[0] = 1; d_rr[0] = 1; step("R3 rank busy");
        d_rr[0] = 0; d_bp[0] = 1; step("R3 bank primed");
        d_bp[0] = 0; d_bp[1] = 1; step("R3 other bank primed");
        idle(TFAW);

        // R9: external activation yields and is recorded
        d_green[0] = 1; e_v = 1; e_ch = 0; e_rk = 1; step("R9 yield");
        step("R9 resume");
        idle(TFAW);

        // R4: three recent activations on rank 2 block it until the first ages out
        for (int i = 0; i < 3; i++) begin e_v = 1; e_ch = 1; e_rk = 0; step("R4 fill"); end
        d_green[2] = 1;
        for (int i = 0; i < 11; i++) step("R4 window");
        idle(TFAW);
        for (int i = 0; i < 2; i++) begin e_v = 1; e_ch = 1; e_rk = 1; step("R4 two"); end
        d_green[3] = 1; step("R4 two allow");
        idle(TFAW);

        // R8: nothing qualifies
        d_green[1] = 1; d_rr[1] = 2; step("R8 no candidate");
        idle(2);

        // R6 / R7: confidence threshold and saturation
        fb_step(0, "R7 down");
        d_green[1] = 1; step("R6 at threshold");
        fb_step(0, "R7 down");
        d_green[1] = 1; step("R6 below threshold");
        for (int i = 0; i < 3; i++) fb_step(1, "R7 up");
        d_green[1] = 1; step("R7 recovered");
        for (int i = 0; i < 10; i++) fb_step(1, "R7 to ceiling");
        fb_step(0, "R7 down");
        d_green[1] = 1; step("R7 ceiling held");
        idle(TFAW);
        for (int i = 0; i < 25; i++) fb_step(0, "R7 to floor");
        for (int i = 0; i < 59; i++) fb_step(1, "R7 climb");
        d_green[1] = 1; step("R7 floor held");
        fb_step(1, "R7 climb");
        d_green[1] = 1; step("R7 floor exit");
        idle(2);

        while (q_v.size() > 0) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule